// File: doc/BRIEF.md
# NoC Command Buffer Register Decoder

This block is the register front end of a network interface. Four command buffers sit 0x800 bytes apart. Each buffer holds these words:

- target and return address words
- a packet tag
- a control word
- length and high byte-enable words
- inline data
- a broadcast exclusion word
- an accumulate instruction word

Firmware fills a buffer's words and then writes 1 to that buffer's trigger register. The block then takes a copy of the buffer and decodes the control word into a transaction descriptor. The descriptor names the transaction kind and the routing fields that were split out of the control word.

Descriptors leave through a valid/ready issue port. While a buffer's command waits there, its trigger register reads 1, and firmware spins on that register until it reads 0. Because the block works from its own copy, firmware may rewrite the buffer as soon as the trigger write is done. The node-ID and endpoint-ID words are inputs to the block. Every buffer returns the same value for them.

Top module: `noc_cmd_regs`

## Requirements
- R1: After reset every buffer word, every trigger register and `iss_valid` read 0.
- R2: Buffer n's words sit at byte offset n*0x800 plus a word offset. The offsets are: target lo/mid/hi 0x00/0x04/0x08, return lo/mid/hi 0x0C/0x10/0x14, tag 0x18, control 0x1C, length 0x20, high byte-enable 0x24, inline data 0x28, exclusion 0x2C, accumulate instruction 0x30. Each reads back what was last written to it. Any other offset reads 0, and writes to it are dropped.
- R3: Offset 0x44 returns `node_id` (y in [11:6], x in [5:0]) and offset 0x48 returns `endpoint_id` in every buffer. Writes to either offset have no effect.
- R4: A write of exactly 0x1 to offset 0x40 of an idle buffer launches its command. The trigger then reads 1 from the next cycle until the issue handshake completes, and reads 0 after that. Any other value written to 0x40 does nothing.
- R5: A trigger written while the same buffer's command is still waiting is ignored, so no second descriptor is issued.
- R6: `iss_kind` decodes from control bits {0 atomic, 1 write, 2 byte-enable, 3 inline}:
  - bit0 set gives 4 (atomic);
  - otherwise bit1 clear gives 0 (read);
  - otherwise bit2 set gives 2 (byte-enable write);
  - otherwise bit3 set gives 3 (inline write);
  - otherwise the result is 1 (DMA write).
- R7: These descriptor fields are taken from the control word and the tag:
  - `iss_txn_id` from tag [13:10] and `iss_hdr_store` from tag bit 9;
  - `iss_nonposted` from control bit 4 and `iss_bcast` from control bit 5;
  - `iss_vc_static` from control bit 7 and `iss_vc` from control [15:13];
  - `iss_src_incl` from control bit 17 and `iss_prio` from control [29:27];
  - `iss_acc_en` from control bit 31.
- R8: The descriptor carries the buffer contents as they were when the trigger was written. Later writes to the buffer do not change it.
- R9: While `iss_valid` is high and `iss_ready` is low, the descriptor and `iss_buf` hold steady.
- R10: Whenever the port is free to choose, the lowest-indexed waiting buffer is presented.
- R11: `iss_buf` names the source buffer. After acceptance, that buffer is not presented again until it is re-triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 13 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 13 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| node_id | input | 12 | Node coordinate, y[11:6] x[5:0] |
| endpoint_id | input | 32 | Endpoint identifier |
| iss_valid | output | 1 | Descriptor available |
| iss_ready | input | 1 | Consumer accepts descriptor |
| iss_buf | output | 2 | Source buffer index |
| iss_kind | output | 3 | Transaction kind |
| iss_txn_id | output | 4 | Transaction ID |
| iss_hdr_store | output | 1 | Header-store flag |
| iss_nonposted | output | 1 | Response expected |
| iss_bcast | output | 1 | Broadcast |
| iss_src_incl | output | 1 | Sender included in broadcast |
| iss_vc_static | output | 1 | Fixed virtual channel |
| iss_vc | output | 3 | Virtual channel number |
| iss_prio | output | 3 | Arbitration priority |
| iss_acc_en | output | 1 | Accumulate atomic enable |
| iss_ctrl | output | 32 | Captured control word |
| iss_tag | output | 32 | Captured packet tag |
| iss_targ_lo | output | 32 | Target address low |
| iss_targ_mid | output | 32 | Target address mid |
| iss_targ_hi | output | 32 | Target coordinate |
| iss_ret_lo | output | 32 | Return address low |
| iss_ret_mid | output | 32 | Return address mid |
| iss_ret_hi | output | 32 | Return coordinate |
| iss_len | output | 32 | Length or low byte-enable |
| iss_be_hi | output | 32 | High byte-enable |
| iss_data | output | 32 | Inline data |
| iss_excl | output | 32 | Broadcast exclusion |
| iss_acc_instr | output | 32 | Accumulate instruction |

## Verification
Some properties are checked by the assertions on every cycle:
- a stalled descriptor holds steady;
- an accepted buffer is not presented again;
- an idle trigger write raises `iss_valid` on the next cycle;
- `iss_kind` always agrees with the captured atomic and write bits.

The directed scenarios cover what needs a chosen history:
- the exact trigger value that launches a command;
- that a trigger written while busy is dropped, counted through handshakes;
- that a rewrite after triggering does not reach the descriptor;
- the lowest-index-first order among buffers that wait together;
- the aliasing of the ID words across buffers.

// File: rtl/noc_cmd_regs.sv
module noc_cmd_regs #(
  parameter int NBUF = 4,
  parameter int STRIDE_LG = 11,
  parameter int NWORD = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [STRIDE_LG+$clog2(NBUF)-1:0] wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [STRIDE_LG+$clog2(NBUF)-1:0] rd_addr,
  output logic [31:0]                 rd_data,
  input  logic [11:0]                 node_id,
  input  logic [31:0]                 endpoint_id,
  output logic                        iss_valid,
  input  logic                        iss_ready,
  output logic [$clog2(NBUF)-1:0]     iss_buf,
  output logic [2:0]                  iss_kind,
  output logic [3:0]                  iss_txn_id,
  output logic                        iss_hdr_store,
  output logic                        iss_nonposted,
  output logic                        iss_bcast,
  output logic                        iss_src_incl,
  output logic                        iss_vc_static,
  output logic [2:0]                  iss_vc,
  output logic [2:0]                  iss_prio,
  output logic                        iss_acc_en,
  output logic [31:0]                 iss_ctrl,
  output logic [31:0]                 iss_tag,
  output logic [31:0]                 iss_targ_lo,
  output logic [31:0]                 iss_targ_mid,
  output logic [31:0]                 iss_targ_hi,
  output logic [31:0]                 iss_ret_lo,
  output logic [31:0]                 iss_ret_mid,
  output logic [31:0]                 iss_ret_hi,
  output logic [31:0]                 iss_len,
  output logic [31:0]                 iss_be_hi,
  output logic [31:0]                 iss_data,
  output logic [31:0]                 iss_excl,
  output logic [31:0]                 iss_acc_instr
);
  localparam int BW     = $clog2(NBUF);
  localparam int WW     = STRIDE_LG - 2;
  localparam int W_TRIG = 'h40 / 4;
  localparam int W_NODE = 'h44 / 4;
  localparam int W_EPID = 'h48 / 4;

  logic [31:0] regs [NBUF][NWORD];
  logic [31:0] snap [NBUF][NWORD];
  logic [NBUF-1:0] pend;
  logic            locked;
  logic [BW-1:0]   sel_q, sel;

  wire [BW-1:0] wbuf  = wr_addr[STRIDE_LG +: BW];
  wire [WW-1:0] wword = wr_addr[STRIDE_LG-1:2];
  wire          wal   = wr_en && (wr_addr[1:0] == 2'b00);
  wire [BW-1:0] rbuf  = rd_addr[STRIDE_LG +: BW];
  wire [WW-1:0] rword = rd_addr[STRIDE_LG-1:2];

  wire trig = wal && int'(wword) == W_TRIG && wr_data == 32'd1 && !pend[wbuf];
  wire hs   = iss_valid && iss_ready;

  always_comb begin
    sel = sel_q;
    if (!locked) begin
      sel = '0;
      for (int b = NBUF - 1; b >= 0; b--)
        if (pend[b]) sel = BW'(b);
    end
  end

  assign iss_valid = |pend;
  assign iss_buf   = sel;

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend[b] <= 1'b0;
          for (int k = 0; k < NWORD; k++) begin
            regs[b][k] <= '0;
            snap[b][k] <= '0;
          end
        end else begin
          for (int k = 0; k < NWORD; k++)
            if (wal && wbuf == BW'(b) && int'(wword) == k) regs[b][k] <= wr_data;
          if (trig && wbuf == BW'(b)) begin
            pend[b] <= 1'b1;
            for (int k = 0; k < NWORD; k++) snap[b][k] <= regs[b][k];
          end else if (hs && sel == BW'(b)) begin
            pend[b] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      sel_q  <= '0;
    end else begin
      locked <= iss_valid && !iss_ready;
      sel_q  <= sel;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (int'(rword) < NWORD)        rd_data = regs[rbuf][rword[3:0]];
      else if (int'(rword) == W_TRIG) rd_data = {31'd0, pend[rbuf]};
      else if (int'(rword) == W_NODE) rd_data = {20'd0, node_id};
      else if (int'(rword) == W_EPID) rd_data = endpoint_id;
    end
  end

  assign iss_targ_lo   = snap[sel][0];
  assign iss_targ_mid  = snap[sel][1];
  assign iss_targ_hi   = snap[sel][2];
  assign iss_ret_lo    = snap[sel][3];
  assign iss_ret_mid   = snap[sel][4];
  assign iss_ret_hi    = snap[sel][5];
  assign iss_tag       = snap[sel][6];
  assign iss_ctrl      = snap[sel][7];
  assign iss_len       = snap[sel][8];
  assign iss_be_hi     = snap[sel][9];
  assign iss_data      = snap[sel][10];
  assign iss_excl      = snap[sel][11];
  assign iss_acc_instr = snap[sel][12];

  assign iss_txn_id    = iss_tag[13:10];
  assign iss_hdr_store = iss_tag[9];
  assign iss_nonposted = iss_ctrl[4];
  assign iss_bcast     = iss_ctrl[5];
  assign iss_vc_static = iss_ctrl[7];
  assign iss_vc        = iss_ctrl[15:13];
  assign iss_src_incl  = iss_ctrl[17];
  assign iss_prio      = iss_ctrl[29:27];
  assign iss_acc_en    = iss_ctrl[31];

  always_comb begin
    if (iss_ctrl[0])       iss_kind = 3'd4;
    else if (!iss_ctrl[1]) iss_kind = 3'd0;
    else if (iss_ctrl[2])  iss_kind = 3'd2;
    else if (iss_ctrl[3])  iss_kind = 3'd3;
    else                   iss_kind = 3'd1;
  end

  // R9
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_buf) && $stable(iss_ctrl)
                                && $stable(iss_targ_lo) && $stable(iss_ret_lo));
  // R11
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> !(iss_valid && iss_buf == $past(iss_buf)));
  // R4
  trig_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[1:0] == 2'b00 && int'(wr_addr[STRIDE_LG-1:2]) == W_TRIG
      && wr_data == 32'd1 && !iss_valid |=> iss_valid);
  // R6
  kind_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ctrl[0] |-> iss_kind == 3'd4);
  // R6
  kind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ctrl[0] && !iss_ctrl[1] |-> iss_kind == 3'd0);
endmodule

// File: tb/test_noc_cmd_regs.sv
module test_noc_cmd_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [12:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [11:0] node_id = 12'h5C3;
  logic [31:0] endpoint_id = 32'hE1D0_0042;
  logic iss_valid, iss_ready = 0;
  logic [1:0] iss_buf;
  logic [2:0] iss_kind, iss_vc, iss_prio;
  logic [3:0] iss_txn_id;
  logic iss_hdr_store, iss_nonposted, iss_bcast, iss_src_incl, iss_vc_static, iss_acc_en;
  logic [31:0] iss_ctrl, iss_tag, iss_targ_lo, iss_targ_mid, iss_targ_hi, iss_ret_lo,
               iss_ret_mid, iss_ret_hi, iss_len, iss_be_hi, iss_data, iss_excl, iss_acc_instr;

  int checks = 0, errors = 0, hs_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n && iss_valid && iss_ready) hs_cnt++;

  noc_cmd_regs i_noc_cmd_regs (.*);

  function automatic logic [12:0] A(int b, int off);
    return 13'(b * 'h800 + off);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int b, int off, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = A(b, off); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdchk(string req, int b, int off, logic [31:0] exp);
    rd_addr = A(b, off);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic accept(string req, int b);
    chk(req, {31'd0, iss_valid}, 32'd1);
    chk(req, {30'd0, iss_buf}, b);
    iss_ready = 1;
    @(negedge clk);
    iss_ready = 0;
  endtask

  task automatic t_reset;
    for (int b = 0; b < 4; b++) begin
      rdchk("R1", b, 'h40, 0);
      rdchk("R1", b, 'h1C, 0);
    end
    chk("R1", {31'd0, iss_valid}, 0);
  endtask

  task automatic t_regs;
    for (int k = 0; k < 13; k++) begin
      wr(1, k * 4, 32'h1100_0000 + k);
      wr(3, k * 4, 32'h3300_0000 + k);
    end
    for (int k = 0; k < 13; k++) begin
      rdchk("R2", 1, k * 4, 32'h1100_0000 + k);
      rdchk("R2", 3, k * 4, 32'h3300_0000 + k);
    end
    rdchk("R2", 2, 'h08, 0);
    wr(0, 'h38, 32'hDEAD_BEEF);
    rdchk("R2", 0, 'h38, 0);
  endtask

  task automatic t_ids;
    for (int b = 0; b < 4; b++) begin
      rdchk("R3", b, 'h44, {20'd0, node_id});
      rdchk("R3", b, 'h48, endpoint_id);
    end
    wr(2, 'h44, 32'h0);
    wr(2, 'h48, 32'h0);
    rdchk("R3", 2, 'h44, {20'd0, node_id});
    rdchk("R3", 0, 'h48, endpoint_id);
  endtask

  task automatic t_trigger;
    int h0;
    wr(0, 'h1C, 32'h2092);
    wr(0, 'h00, 32'hAAAA_0001);
    wr(0, 'h40, 32'h2);
    rdchk("R4", 0, 'h40, 0);
    chk("R4", {31'd0, iss_valid}, 0);
    wr(0, 'h40, 32'h1);
    rdchk("R4", 0, 'h40, 1);
    chk("R6", {29'd0, iss_kind}, 1);
    chk("R7", {28'd0, iss_nonposted, iss_vc_static, iss_vc}, {28'd0, 1'b1, 1'b1, 3'd1});
    chk("R7", {31'd0, iss_bcast}, 0);
    wr(0, 'h00, 32'hBBBB_0002);
    chk("R8", iss_targ_lo, 32'hAAAA_0001);
    rdchk("R2", 0, 'h00, 32'hBBBB_0002);
    wr(0, 'h40, 32'h1);
    @(negedge clk);
    chk("R9", iss_targ_lo, 32'hAAAA_0001);
    rdchk("R4", 0, 'h40, 1);
    h0 = hs_cnt;
    accept("R11", 0);
    rdchk("R4", 0, 'h40, 0);
    chk("R5", {31'd0, iss_valid}, 0);
    repeat (3) @(negedge clk);
    chk("R5", hs_cnt - h0, 1);
  endtask

  task automatic issue_one(string req, logic [31:0] ctrl, logic [2:0] exp);
    wr(2, 'h1C, ctrl);
    wr(2, 'h40, 32'h1);
    chk(req, {29'd0, iss_kind}, {29'd0, exp});
    accept(req, 2);
  endtask

  task automatic t_kinds;
    issue_one("R6", 32'h0, 3'd0);
    issue_one("R6", 32'h2, 3'd1);
    issue_one("R6", 32'h6, 3'd2);
    issue_one("R6", 32'hA, 3'd3);
    issue_one("R6", 32'h1, 3'd4);
    issue_one("R6", 32'hF, 3'd4);
    issue_one("R6", 32'h8, 3'd0);
  endtask

  task automatic t_fields;
    wr(3, 'h18, (32'hB << 10) | (32'h1 << 9));
    wr(3, 'h1C, 32'h8000_0000 | (32'd5 << 27) | (32'h1 << 17) | 32'h20 | 32'h2);
    wr(3, 'h40, 32'h1);
    chk("R7", {28'd0, iss_txn_id}, 32'hB);
    chk("R7", {31'd0, iss_hdr_store}, 1);
    chk("R7", {29'd0, iss_prio}, 5);
    chk("R7", {29'd0, iss_bcast, iss_src_incl, iss_acc_en}, 32'h7);
    chk("R7", {30'd0, iss_nonposted, iss_vc_static}, 0);
    chk("R8", iss_ret_hi, 32'h3300_0005);
    accept("R11", 3);
  endtask

  task automatic t_priority;
    wr(3, 'h00, 32'h3);
    wr(1, 'h00, 32'h1);
    wr(0, 'h00, 32'h0);
    wr(3, 'h40, 32'h1);
    wr(1, 'h40, 32'h1);
    wr(0, 'h40, 32'h1);
    chk("R9", {30'd0, iss_buf}, 3);
    accept("R10", 3);
    chk("R10", iss_targ_lo, 32'h0);
    accept("R10", 0);
    chk("R10", iss_targ_lo, 32'h1);
    accept("R10", 1);
    chk("R11", {31'd0, iss_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_ids;
    t_trigger;
    t_kinds;
    t_fields;
    t_priority;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule